// File: doc/BRIEF.md
# 24-Bit Pixel Word Unpacker

This block sits between a frame-buffer word stream and a display pixel pipeline. It accepts 32-bit words over a valid/ready handshake. For each output beat it presents one 24-bit RGB pixel, also over a valid/ready handshake. Two storage layouts are supported. The dense layout fits four pixels into every three words, so pixels cross word boundaries. The loose layout puts one pixel in the low three bytes of each word and ignores the top byte.

The unit runs only while both the 24-bit colour mode and the active-matrix panel mode are selected. At all other times it neither accepts words nor offers pixels, and its internal state stays as it was. A frame-start strobe realigns the dense-layout group to its first word, discards any partial pixel, and samples the layout select. A layout change in the middle of a frame therefore takes effect only at the next strobe.

The handshakes are combinational: the output valid follows the input valid, and the input ready follows the output ready. The block adds no cycle of latency and needs no buffering beyond a 16-bit residue.

Top module: `pix24_unpacker`

## Requirements
- R1: When `mode_24b_en` or `mode_active_en` is low, `out_valid` and `in_ready` are both 0, no word is consumed and the group position is kept.
- R2: In the loose layout (`layout_sel` = 1 at the last frame start), each accepted word gives one pixel equal to word bits [23:0]; bits [31:24] never reach the output.
- R3: In the dense layout (`layout_sel` = 0), the first pixel of a group is bits [23:0] of the group's first word, and that word is consumed with it.
- R4: The second pixel of a dense group is {word1[15:0], word0[31:24]}, and word1 is consumed with it.
- R5: The third pixel of a dense group is {word2[7:0], word1[31:16]}. It is offered while `in_ready` stays 0, so word2 is not consumed.
- R6: The fourth pixel of a dense group is word2[31:8]. It is emitted from the same word2 that R5 read, and word2 is consumed with it.
- R7: In a cycle with `frame_start` high, `out_valid` and `in_ready` are both 0. The next word accepted after it is treated as the first word of a dense group, and any partial pixel is dropped.
- R8: `layout_sel` is sampled only in a `frame_start` cycle. The layout after reset is dense.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is 0, and no pixel is dropped or repeated.
- R10: During and right after reset with no input offered, `out_valid` and `in_ready` are 0, and the first frame decodes in the dense layout with no frame start needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_24b_en | input | 1 | 24-bit colour mode selected |
| mode_active_en | input | 1 | Active-matrix panel mode selected |
| layout_sel | input | 1 | 0 = four pixels per three words, 1 = one pixel per word (sampled at frame start) |
| frame_start | input | 1 | Frame boundary strobe |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Frame-buffer word |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| out_valid | output | 1 | Output pixel valid |
| out_pixel | output | 24 | RGB pixel |
| out_ready | input | 1 | Downstream accepts the pixel |

## Verification
A frame-start strobe can land in the same cycle as a pending pixel. The most telling case is the fourth pixel of a dense group, whose word is already on the input but not yet consumed. The bench drives a dense frame until the reference model reaches that pixel, then raises the strobe with valid and ready both high. It checks that nothing transfers in that cycle and that the next accepted word decodes as the first word of a new group. Random strobes, back-pressure and mode-enable drops are mixed in as well, and the byte-addressed reference model judges every cycle.

// File: rtl/pix24_pkg.sv
// Shared constants and types for the 24-bit pixel word unpacker.
// Assumes a fixed 32-bit word and 24-bit pixel; the dense layout
// decodes four pixels from three words.
package pix24_pkg;
    localparam int WORD_W = 32;
    localparam int PIX_W  = 24;
    localparam int BYTE_W = 8;
    localparam int RES_W  = WORD_W - PIX_W + BYTE_W;   // 16-bit residue

    typedef enum logic [1:0] {
        PH_W0 = 2'd0,
        PH_W1 = 2'd1,
        PH_W2 = 2'd2
    } phase_e;

    typedef enum logic {
        LAY_DENSE = 1'b0,
        LAY_LOOSE = 1'b1
    } layout_e;
endpackage

// File: rtl/pix24_phase_ctrl.sv
// Group position tracker: the word phase within a dense group, the
// half flag that splits the third word into two pixels, and the
// layout latched at frame start. It assumes that the takes are
// already gated off in a frame-start cycle.
module pix24_phase_ctrl
    import pix24_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    frame_start,
    input  logic    layout_sel,
    input  logic    word_take,
    input  logic    pix_take,
    output phase_e  phase,
    output logic    half,
    output layout_e layout
);
    phase_e  phase_q;
    logic    half_q;
    layout_e layout_q;

    // Advance the group position on each handshake; a frame start realigns it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_W0;
            half_q   <= 1'b0;
            layout_q <= LAY_DENSE;
        end else if (frame_start) begin
            phase_q  <= PH_W0;
            half_q   <= 1'b0;
            layout_q <= layout_e'(layout_sel);
        end else if (layout_q == LAY_DENSE) begin
            if (phase_q == PH_W2 && !half_q && pix_take) begin
                half_q <= 1'b1;
            end else if (word_take) begin
                half_q <= 1'b0;
                case (phase_q)
                    PH_W0:   phase_q <= PH_W1;
                    PH_W1:   phase_q <= PH_W2;
                    default: phase_q <= PH_W0;
                endcase
            end
        end
    end

    assign phase  = phase_q;
    assign half   = half_q;
    assign layout = layout_q;

    a_r7_group_realigned: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (phase_q == PH_W0 && !half_q));
    a_r5_half_in_last_word: assert property (@(posedge clk) disable iff (!rst_n)
        half_q |-> (phase_q == PH_W2));
    a_r8_layout_held: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(layout_q));
    a_r3_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q != 2'd3);
endmodule

// File: rtl/pix24_residue.sv
// Residue register: holds the bytes of a pixel that spills into the
// next word. The first word leaves one byte, the second leaves two.
// A frame start clears it.
module pix24_residue
    import pix24_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  phase_e            phase,
    input  logic [WORD_W-1:0] word,
    output logic [RES_W-1:0]  residue
);
    logic [RES_W-1:0] res_q;

    // Capture the spill-over bytes of the word being consumed.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            res_q <= '0;
        end else if (load) begin
            if (phase == PH_W0)
                res_q <= {{(RES_W-BYTE_W){1'b0}}, word[WORD_W-1 -: BYTE_W]};
            else if (phase == PH_W1)
                res_q <= word[WORD_W-1 -: RES_W];
        end
    end

    assign residue = res_q;

    a_r9_residue_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clear) |=> $stable(res_q));
endmodule

// File: rtl/pix24_lane_mux.sv
// Pixel assembly: picks the output pixel from the current word and
// the residue for the layout and group position. It also flags the
// one beat (third pixel of a group) that must not consume the word.
// Purely combinational.
module pix24_lane_mux
    import pix24_pkg::*;
(
    input  layout_e           layout,
    input  phase_e            phase,
    input  logic              half,
    input  logic [WORD_W-1:0] word,
    input  logic [RES_W-1:0]  residue,
    output logic [PIX_W-1:0]  pixel,
    output logic              hold_word
);
    // Select the byte lanes that form the current pixel.
    always_comb begin
        hold_word = 1'b0;
        if (layout == LAY_LOOSE) begin
            pixel = word[PIX_W-1:0];
        end else begin
            case (phase)
                PH_W0: pixel = word[PIX_W-1:0];
                PH_W1: pixel = {word[RES_W-1:0], residue[BYTE_W-1:0]};
                default: begin
                    if (half) begin
                        pixel = word[WORD_W-1 -: PIX_W];
                    end else begin
                        pixel     = {word[BYTE_W-1:0], residue};
                        hold_word = 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pix24_unpacker.sv
// 24-bit pixel word unpacker top. It gates both handshakes on the two
// mode enables and the frame strobe, and joins the phase tracker,
// residue and lane mux. It assumes the upstream holds in_data stable
// while in_valid is high and in_ready is low.
module pix24_unpacker
    import pix24_pkg::*;
#(
    parameter int IN_W  = WORD_W,
    parameter int OUT_W = PIX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_24b_en,
    input  logic             mode_active_en,
    input  logic             layout_sel,
    input  logic             frame_start,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_pixel,
    input  logic             out_ready
);
    logic             run;
    logic             word_take;
    logic             pix_take;
    logic             hold_word;
    phase_e           phase;
    logic             half;
    layout_e          layout;
    logic [RES_W-1:0] residue;

    // Active only with both modes on and outside a frame-start cycle.
    assign run       = mode_24b_en && mode_active_en && !frame_start;
    assign out_valid = run && in_valid;
    assign in_ready  = run && out_ready && !hold_word;
    assign word_take = in_valid && in_ready;
    assign pix_take  = out_valid && out_ready;

    pix24_phase_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .layout_sel  (layout_sel),
        .word_take   (word_take),
        .pix_take    (pix_take),
        .phase       (phase),
        .half        (half),
        .layout      (layout)
    );

    pix24_residue u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (frame_start),
        .load    (word_take),
        .phase   (phase),
        .word    (in_data),
        .residue (residue)
    );

    pix24_lane_mux u_mux (
        .layout    (layout),
        .phase     (phase),
        .half      (half),
        .word      (in_data),
        .residue   (residue),
        .pixel     (out_pixel),
        .hold_word (hold_word)
    );

    a_r9_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !frame_start) |=> ($stable(phase) && $stable(half) && $stable(residue)));
    a_r1_off_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mode_24b_en && mode_active_en) && !frame_start) |=> ($stable(phase) && $stable(half)));
    a_r5_third_pixel_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        (layout == LAY_DENSE && phase == PH_W2 && !half) |-> !word_take);
endmodule

// File: tb/sim_pix24_unpacker.sv
// Bench: a byte-addressed reference model predicts the handshakes and
// pixel on every clock and compares them at the falling edge.
module sim_pix24_unpacker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_24b_en, mode_active_en, layout_sel, frame_start;
    logic        in_valid, in_ready, out_valid, out_ready;
    logic [31:0] in_data;
    logic [23:0] out_pixel;

    always #10 clk = ~clk;

    pix24_unpacker u0 (
        .clk(clk), .rst_n(rst_n), .mode_24b_en(mode_24b_en),
        .mode_active_en(mode_active_en), .layout_sel(layout_sel),
        .frame_start(frame_start), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_pixel(out_pixel),
        .out_ready(out_ready)
    );

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;
    logic [31:0] wq[$];
    int          n  = 0;       // pixels emitted in this frame
    int          wi = 0;       // words consumed in this frame
    bit          lay_m = 0;    // 1 = loose layout
    bit          first_frame = 1;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(int k);
        return wq[k/4][8*(k%4) +: 8];
    endfunction

    task automatic new_frame();
        wq.delete();
        for (int i = 0; i < $urandom_range(1, 12); i++) wq.push_back($urandom());
    endtask

    task automatic step(bit e24, bit eact, bit fs, bit sel, bit iv, bit ordy);
        bit          en, gate, have, cons, exp_ov, exp_ir;
        logic [23:0] exp_pix;
        string       tag;
        @(negedge clk);
        mode_24b_en = e24; mode_active_en = eact; frame_start = fs;
        layout_sel = sel; out_ready = ordy;
        have = (wi < wq.size());
        in_valid = iv && have;
        in_data  = have ? wq[wi] : $urandom();
        #1;
        en   = e24 && eact;
        gate = en && !fs;
        cons = lay_m ? 1'b1 : (((3*n+5)/4) != ((3*n+2)/4));
        exp_ov = gate && in_valid;
        exp_ir = gate && ordy && cons;
        exp_pix = '0;
        if (exp_ov) exp_pix = lay_m ? wq[wi][23:0] : {fbyte(3*n+2), fbyte(3*n+1), fbyte(3*n)};
        if (!en)                       tag = "R1";
        else if (fs)                   tag = "R7";
        else if (exp_ov && !ordy)      tag = "R9";
        else if (sel != lay_m)         tag = "R8";
        else if (lay_m)                tag = "R2";
        else if (first_frame)          tag = "R10";
        else case (n % 4)
            0: tag = "R3";
            1: tag = "R4";
            2: tag = "R5";
            default: tag = "R6";
        endcase
        chk(tag, {31'b0, out_valid}, {31'b0, exp_ov});
        chk(tag, {31'b0, in_ready}, {31'b0, exp_ir});
        if (exp_ov) chk(tag, {8'b0, out_pixel}, {8'b0, exp_pix});
        @(posedge clk);
        if (fs) begin
            lay_m = sel; n = 0; wi = 0; first_frame = 0;
            new_frame();
        end else begin
            if (exp_ov && ordy) n++;
            if (exp_ir && in_valid) wi++;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 0; mode_24b_en = 0; mode_active_en = 0; layout_sel = 1;
        frame_start = 0; in_valid = 0; in_data = '0; out_ready = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", {31'b0, out_valid}, 32'd0);   // R10 during reset
        chk("R10", {31'b0, in_ready}, 32'd0);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk("R10", {31'b0, out_valid}, 32'd0);   // R10 after reset, idle
        chk("R10", {31'b0, in_ready}, 32'd0);
        // First frame: dense without any frame start (R10, R8 default).
        wq.delete();
        for (int i = 0; i < 6; i++) wq.push_back($urandom());
        for (int c = 0; c < 12; c++) step(1, 1, 0, 1, 1, 1);
        // Directed: frame start lands on a pending fourth pixel (R7, R6).
        step(1, 1, 1, 0, 1, 1);
        for (int c = 0; c < 8 && n % 4 != 3; c++) step(1, 1, 0, 0, 1, 1);
        step(1, 1, 1, 0, 1, 1);
        for (int c = 0; c < 6; c++) step(1, 1, 0, 0, 1, c[0]);
        // Directed: loose layout ignores the top byte (R2).
        step(1, 1, 1, 1, 1, 1);
        for (int c = 0; c < 8; c++) step(1, 1, 0, 1, 1, 1);
        // Randomised frames: stalls, enable drops, mid-frame selects.
        for (int f = 0; f < 60; f++) begin
            bit s;
            s = $urandom_range(0, 1);
            step(1, 1, 1, s, $urandom_range(0, 1), 1);
            for (int c = 0; c < 40; c++) begin
                bit fs, e24, eact;
                if ($urandom_range(0, 4) == 0) s = ~s;
                e24  = ($urandom_range(0, 9) != 0);
                eact = ($urandom_range(0, 9) != 0);
                fs   = ($urandom_range(0, 49) == 0);
                step(e24, eact, fs, s, ($urandom_range(0, 4) != 0), ($urandom_range(0, 9) < 7));
            end
        end
        finish_run();
    end
endmodule